// File: doc/BRIEF.md
# Stereo Half-dB Volume Stage with Soft Mute

This block scales a stereo stream of 24-bit signed samples by a gain chosen separately for each channel. Each channel's gain comes from an 8-bit code counting half-decibel steps. The range runs from 24 dB of boost down to 63.5 dB of cut, and one code is reserved for silence. A mute request does not cut the sound at once. It fades both channels in half-decibel steps, one step per sample, until the output reaches exact zero. Releasing the request fades the sound back in at the same rate.

When an automatic-gain loop upstream takes over the level, its enable input makes the stage ignore the per-channel codes and pass the samples at unity gain. The soft mute still applies in that mode.

The decibel-to-linear conversion uses a twelve-entry mantissa for the half-decibel steps inside one 6 dB octave, plus a binary shift for each whole octave. Every result is rounded and clipped to 24 bits.

Top module: `stereo_db_gain`

## Requirements
- R1: The left output depends only on `gain_left` and the right output only on `gain_right`. The same sample under different codes gives each channel its own result.
- R2: A gain code is a two's-complement count of 0.5 dB steps. Code 0x00 passes the sample through exactly.
- R3: Positive codes boost the signal: 0x0C gives twice the input and 0x30 gives 16 times the input. Codes 0x31 to 0x7F act exactly like 0x30.
- R4: For a net step count e, let q = floor(e/12) and r = e − 12q. The output is round-half-up of x · M(r) · 2^q / 2^14, where M(r) = round(2^14 · 2^(r/12)). So code 0xF4 halves the sample, and 0x81 is the lowest non-silent setting.
- R5: Results above 8388607 clip to 8388607, and results below −8388608 clip to −8388608.
- R6: Code 0x80 makes that channel output exact zero, while the other channel is unaffected.
- R7: A ramp level L starts at 0. Each input sample is scaled with net step count e = (channel code) − L, and L then changes. While `mute_req` is high, L rises by one per sample up to 256. At L = 256 both outputs are exact zero.
- R8: While `mute_req` is low, L falls by one per sample until it reaches 0, so the gain returns in 0.5 dB steps.
- R9: With `agc_en` high, both channel codes are treated as 0x00, including 0x80. The ramp level still applies.
- R10: A sample accepted at a clock edge appears on the outputs at the third edge, with `out_valid` high for one cycle. The outputs hold their values between results.
- R11: Reset clears the outputs and `out_valid` to zero and returns the ramp level to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample pair is present |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| gain_left | input | 8 | Left gain code, signed half-dB count |
| gain_right | input | 8 | Right gain code, signed half-dB count |
| mute_req | input | 1 | Fade to silence while high, fade back while low |
| agc_en | input | 1 | Bypass both gain codes |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_left | output | 24 | Scaled and clipped left sample |
| out_right | output | 24 | Scaled and clipped right sample |

## Verification
A ramp level that is off by even one step changes the very next output by a 0.5 dB ratio. Sending a large constant sample through a full fade and back therefore shows a wrong level on the first affected result, three cycles after its input. A wrong mantissa or octave split shows up at once as a mismatch against the exact rounded value for that code. A lost silence flag shows as a non-zero output at the ramp endpoint or under code 0x80. A broken clipping path shows only when a sample is large enough to overflow, so full-scale inputs are driven under maximum boost.

// File: rtl/vol_pkg.sv
package vol_pkg;
  // Fractional bits of the per-octave mantissa.
  localparam int MANT_FRAC = 14;
  // Mantissa width: 2^(11/12) * 2^14 stays below 2^15.
  localparam int MANT_W = MANT_FRAC + 1;
  // Half-dB steps in one 6 dB octave.
  localparam int STEPS_PER_OCT = 12;

  // 2^(r/12) scaled by 2^14 and rounded.
  function automatic logic [MANT_W-1:0] mant_of(input logic [3:0] r);
    logic [MANT_W-1:0] m;
    case (r)
      4'd0:    m = 15'd16384;
      4'd1:    m = 15'd17358;
      4'd2:    m = 15'd18390;
      4'd3:    m = 15'd19484;
      4'd4:    m = 15'd20643;
      4'd5:    m = 15'd21870;
      4'd6:    m = 15'd23170;
      4'd7:    m = 15'd24548;
      4'd8:    m = 15'd26008;
      4'd9:    m = 15'd27554;
      4'd10:   m = 15'd29193;
      default: m = 15'd30929;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vol_mute_ramp.sv
module vol_mute_ramp #(
  parameter int MUTE_STEPS = 256,
  parameter int LVL_W      = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             mute_i,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(MUTE_STEPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= '0;
    end else if (step_i) begin
      if (mute_i && level_o != FULL)
        level_o <= level_o + LVL_W'(1);
      else if (!mute_i && level_o != '0)
        level_o <= level_o - LVL_W'(1);
    end
  end

  assert_ramp_down_R7: assert property (@(posedge clk) disable iff (rst)
    (step_i && mute_i && level_o != FULL) |=> level_o == $past(level_o) + LVL_W'(1));

  assert_ramp_up_R8: assert property (@(posedge clk) disable iff (rst)
    (step_i && !mute_i && level_o != '0) |=> level_o == $past(level_o) - LVL_W'(1));

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
    level_o <= FULL);

  assert_level_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(level_o));
endmodule

// File: rtl/vol_gain_decode.sv
module vol_gain_decode #(
  parameter int CODE_W     = 8,
  parameter int MUTE_STEPS = 256,
  parameter int MAX_BOOST  = 48,
  parameter int LVL_W      = 9,
  parameter int OFS_Q      = 32,
  parameter int SH_W       = 6
) (
  input  logic [CODE_W-1:0]           code_i,
  input  logic                        agc_i,
  input  logic [LVL_W-1:0]            level_i,
  output logic [vol_pkg::MANT_W-1:0]  mant_o,
  output logic [SH_W-1:0]             shift_o,
  output logic                        zero_o
);
  import vol_pkg::*;

  localparam int E_W = ((LVL_W > CODE_W) ? LVL_W : CODE_W) + 2;
  localparam int OFS = OFS_Q * STEPS_PER_OCT;
  localparam logic [CODE_W-1:0] SILENT = {1'b1, {(CODE_W-1){1'b0}}};

  logic signed [E_W-1:0] g;
  logic signed [E_W-1:0] e;
  logic [E_W-1:0]        u;
  logic [E_W-1:0]        q_off;
  logic [3:0]            r;
  logic                  silent_code;

  always_comb begin
    silent_code = (code_i == SILENT);
    if (agc_i)
      g = '0;
    else if ($signed(code_i) > MAX_BOOST)
      g = E_W'(MAX_BOOST);
    else
      g = E_W'($signed(code_i));
    e       = g - $signed({{(E_W-LVL_W){1'b0}}, level_i});
    u       = $unsigned(e) + E_W'(OFS);
    q_off   = u / E_W'(STEPS_PER_OCT);
    r       = 4'(u % E_W'(STEPS_PER_OCT));
    shift_o = SH_W'(MANT_FRAC + OFS_Q) - SH_W'(q_off);
    mant_o  = mant_of(r);
    zero_o  = (!agc_i && silent_code) || (level_i == LVL_W'(MUTE_STEPS));
  end
endmodule

// File: rtl/vol_scale_sat.sv
module vol_scale_sat #(
  parameter int DATA_W = 24,
  parameter int SH_W   = 6,
  parameter int SH_MAX = 46
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        valid_i,
  input  logic [DATA_W-1:0]           sample_i,
  input  logic [vol_pkg::MANT_W-1:0]  mant_i,
  input  logic [SH_W-1:0]             shift_i,
  input  logic                        zero_i,
  output logic                        valid_o,
  output logic [DATA_W-1:0]           sample_o
);
  import vol_pkg::*;

  localparam int PROD_W = DATA_W + MANT_W + 1;
  localparam int EXT_W  = ((PROD_W > SH_MAX + 1) ? PROD_W : SH_MAX + 1) + 1;
  localparam logic signed [EXT_W-1:0] MAXV =
    {{(EXT_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] MINV =
    {{(EXT_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  // Multiply stage.
  logic signed [PROD_W-1:0] prod_q;
  logic [SH_W-1:0]          sh_q;
  logic                     zero_q;
  logic                     v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      prod_q <= '0;
      sh_q   <= '0;
      zero_q <= 1'b0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        prod_q <= $signed(sample_i) * $signed({1'b0, mant_i});
        sh_q   <= shift_i;
        zero_q <= zero_i;
      end
    end
  end

  // Round, shift and clip.
  logic signed [EXT_W-1:0] ext, bias, sum, shr;
  logic [DATA_W-1:0]       clipped;

  always_comb begin
    ext  = EXT_W'(prod_q);
    bias = {{(EXT_W-1){1'b0}}, 1'b1} << (sh_q - SH_W'(1));
    sum  = ext + bias;
    shr  = sum >>> sh_q;
    if (shr > MAXV)
      clipped = MAXV[DATA_W-1:0];
    else if (shr < MINV)
      clipped = MINV[DATA_W-1:0];
    else
      clipped = shr[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o <= v_q;
      if (v_q)
        sample_o <= zero_q ? '0 : clipped;
    end
  end

  assert_zero_out_R6: assert property (@(posedge clk) disable iff (rst)
    $past(v_q && zero_q) |-> (valid_o && sample_o == '0));

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(valid_i, 2));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(sample_o));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (v_q && !zero_q && prod_q >= 0) |=> !sample_o[DATA_W-1]);
endmodule

// File: rtl/stereo_db_gain.sv
module stereo_db_gain #(
  parameter int DATA_W     = 24,
  parameter int CODE_W     = 8,
  parameter int MUTE_STEPS = 256,
  parameter int MAX_BOOST  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic [CODE_W-1:0] gain_left,
  input  logic [CODE_W-1:0] gain_right,
  input  logic              mute_req,
  input  logic              agc_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right
);
  import vol_pkg::*;

  localparam int NCH    = 2;
  localparam int LVL_W  = $clog2(MUTE_STEPS + 1);
  localparam int OFS_Q  = (MUTE_STEPS + 2**(CODE_W-1) + STEPS_PER_OCT - 1) / STEPS_PER_OCT;
  localparam int SH_MAX = MANT_FRAC + OFS_Q;
  localparam int SH_W   = $clog2(SH_MAX + 1);

  logic [LVL_W-1:0] level;

  vol_mute_ramp #(.MUTE_STEPS(MUTE_STEPS), .LVL_W(LVL_W)) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .step_i (in_valid),
    .mute_i (mute_req),
    .level_o(level)
  );

  logic [DATA_W-1:0] smp_in  [NCH];
  logic [CODE_W-1:0] code_in [NCH];
  logic [DATA_W-1:0] smp_out [NCH];
  logic              vout    [NCH];

  assign smp_in[0]  = in_left;
  assign smp_in[1]  = in_right;
  assign code_in[0] = gain_left;
  assign code_in[1] = gain_right;

  logic                 s1_valid;
  logic [DATA_W-1:0]    s1_smp  [NCH];
  logic [MANT_W-1:0]    s1_mant [NCH];
  logic [SH_W-1:0]      s1_sh   [NCH];
  logic                 s1_zero [NCH];

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [MANT_W-1:0] mant_c;
    logic [SH_W-1:0]   sh_c;
    logic              zero_c;

    vol_gain_decode #(
      .CODE_W(CODE_W), .MUTE_STEPS(MUTE_STEPS), .MAX_BOOST(MAX_BOOST),
      .LVL_W(LVL_W), .OFS_Q(OFS_Q), .SH_W(SH_W)
    ) u_dec (
      .code_i (code_in[ch]),
      .agc_i  (agc_en),
      .level_i(level),
      .mant_o (mant_c),
      .shift_o(sh_c),
      .zero_o (zero_c)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_smp[ch]  <= '0;
        s1_mant[ch] <= '0;
        s1_sh[ch]   <= '0;
        s1_zero[ch] <= 1'b0;
      end else if (in_valid) begin
        s1_smp[ch]  <= smp_in[ch];
        s1_mant[ch] <= mant_c;
        s1_sh[ch]   <= sh_c;
        s1_zero[ch] <= zero_c;
      end
    end

    vol_scale_sat #(.DATA_W(DATA_W), .SH_W(SH_W), .SH_MAX(SH_MAX)) u_scale (
      .clk     (clk),
      .rst     (rst),
      .valid_i (s1_valid),
      .sample_i(s1_smp[ch]),
      .mant_i  (s1_mant[ch]),
      .shift_i (s1_sh[ch]),
      .zero_i  (s1_zero[ch]),
      .valid_o (vout[ch]),
      .sample_o(smp_out[ch])
    );
  end

  assign out_valid = vout[0];
  assign out_left  = smp_out[0];
  assign out_right = smp_out[1];

  assert_bypass_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && agc_en && level == '0) |=>
      (s1_mant[0] == MANT_W'(1 << MANT_FRAC) && s1_sh[0] == SH_W'(MANT_FRAC) && !s1_zero[0]));

  assert_lanes_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    vout[0] == vout[1]);
endmodule

// File: tb/tb_stereo_db_gain.sv
`timescale 1ns/1ps
module tb_stereo_db_gain;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic [7:0]  gain_left = '0, gain_right = '0;
  logic        mute_req = 1'b0, agc_en = 1'b0;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  int checks = 0;
  int failures = 0;
  int lvl = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stereo_db_gain dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .gain_left(gain_left), .gain_right(gain_right), .mute_req(mute_req), .agc_en(agc_en),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint model(input longint x, input logic [7:0] code,
                                   input bit agc, input int level);
    int g, e, u, q, r, s;
    longint m, p, res;
    if (level >= 256) return 0;
    if (agc) g = 0;
    else if (code == 8'h80) return 0;
    else begin
      g = int'($signed(code));
      if (g > 48) g = 48;
    end
    e = g - level;
    u = e + 384;
    q = u / 12 - 32;
    r = u % 12;
    m = longint'($rtoi($floor(16384.0 * $pow(2.0, real'(r) / 12.0) + 0.5)));
    p = x * m;
    s = 14 - q;
    res = (p + (64'sd1 <<< (s - 1))) >>> s;
    if (res > 8388607) res = 8388607;
    if (res < -8388608) res = -8388608;
    return res;
  endfunction

  // Drive one pair at a falling edge and check the result three rising edges later.
  task automatic send(input longint xl, input longint xr, input logic [7:0] gl,
                      input logic [7:0] gr, input bit mu, input bit ag, input string tag);
    longint el, er;
    el = model(xl, gl, ag, lvl);
    er = model(xr, gr, ag, lvl);
    if (mu && lvl < 256) lvl++;
    else if (!mu && lvl > 0) lvl--;
    in_left = 24'(xl); in_right = 24'(xr);
    gain_left = gl; gain_right = gr;
    mute_req = mu; agc_en = ag; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({tag, " R10 valid"}, longint'(out_valid), 1);
    check({tag, " left"}, longint'($signed(out_left)), el);
    check({tag, " right"}, longint'($signed(out_right)), er);
  endtask

  task automatic t_reset;
    check("R11 valid in reset", longint'(out_valid), 0);
    check("R11 left in reset", longint'(out_left), 0);
    check("R11 right in reset", longint'(out_right), 0);
    @(negedge clk); rst = 1'b0;
    send(123456, -654321, 8'h00, 8'h00, 0, 0, "R11 R2 unity after reset");
  endtask

  task automatic t_independent;
    send(1000, 1000, 8'h00, 8'hF4, 0, 0, "R1 split codes");
    send(-7777, 4242, 8'hFF, 8'h0C, 0, 0, "R1 mixed codes");
  endtask

  task automatic t_boost;
    send(1000, -1000, 8'h30, 8'h0C, 0, 0, "R3 max boost");
    send(1000, 1000, 8'h7F, 8'h31, 0, 0, "R3 clamp above max");
    check("R3 x16", 16000, longint'($signed(out_left)));
  endtask

  task automatic t_atten;
    send(1000, -3, 8'hF4, 8'hF4, 0, 0, "R4 half");
    check("R4 half exact", longint'($signed(out_left)), 500);
    send(8388607, -8388608, 8'h81, 8'hE5, 0, 0, "R4 deep cut");
    send(5000001, 333, 8'hFF, 8'hC3, 0, 0, "R4 odd steps");
  endtask

  task automatic t_saturate;
    send(8388607, -8388608, 8'h30, 8'h30, 0, 0, "R5 clip");
    check("R5 top", longint'($signed(out_left)), 8388607);
    send(-8388608, 4000000, 8'h00, 8'h02, 0, 0, "R5 edge");
  endtask

  task automatic t_silent_code;
    send(2000000, 2000000, 8'h80, 8'h00, 0, 0, "R6 silent left");
    check("R6 right untouched", longint'($signed(out_right)), 2000000);
  endtask

  task automatic t_ramp;
    for (int k = 0; k < 258; k++)
      send(4000000, -4000000, 8'h00, 8'h06, 1, 0, "R7 fade");
    check("R7 endpoint zero", longint'(out_left), 0);
    for (int k = 0; k < 258; k++)
      send(4000000, -4000000, 8'h00, 8'h06, 0, 0, "R8 return");
    check("R8 back to unity", longint'($signed(out_left)), 4000000);
  endtask

  task automatic t_agc;
    send(777777, -777777, 8'h80, 8'hF4, 0, 1, "R9 bypass");
    check("R9 unity", longint'($signed(out_left)), 777777);
    for (int k = 0; k < 3; k++) send(600000, 600000, 8'h30, 8'h80, 1, 1, "R9 ramp kept");
    for (int k = 0; k < 3; k++) send(600000, 600000, 8'h30, 8'h80, 0, 1, "R9 ramp back");
  endtask

  task automatic t_hold;
    longint l0, r0;
    send(31337, -31337, 8'h00, 8'h00, 0, 0, "R10 hold base");
    l0 = longint'(out_left); r0 = longint'(out_right);
    repeat (4) @(negedge clk);
    check("R10 no pulse idle", longint'(out_valid), 0);
    check("R10 left held", longint'(out_left), l0);
    check("R10 right held", longint'(out_right), r0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_independent();
    t_boost();
    t_atten();
    t_saturate();
    t_silent_code();
    t_ramp();
    t_agc();
    t_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R10 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule